// File: doc/BRIEF.md
# Two-Way Sequential Lookup Controller with Steered Probe Order

This block controls lookup and replacement for a two-way set-associative cache whose tag store is searched one way per cycle. Every request brings an effective address together with the base-register value and offset that formed it. A prediction index, taken either from the effective address or from a carry-free XOR of base and offset, selects one bit of a steering table. That bit names the way to compare first. A second comparison in the other way happens only if that way's rehash bit allows it.

Replacement is kept apart from probe ordering. Each set has one most-recently-used bit. On a miss the opposite way is reported as the victim, which gives exact LRU across the two ways. A later refill pulse installs the missed line in that victim way. The controller holds tags, valid bits, the MRU bits, the steering bits and the rehash bits. Line data, memory timing and write-back live elsewhere.

Top module: `psa_lookup_ctrl`

## Requirements
- R1: After reset, `busy` and every response output are low. All valid, MRU, steering and rehash bits are clear, so the first lookup of any address misses after one probe and reports victim way 1.
- R2: The set index is address bits [11:5] and the tag is bits [31:12]. With the default `USE_XOR=1`, the steering index is bits [12:5] of `req_base ^ req_offset`. With `USE_XOR=0`, it is bits [12:5] of `req_addr`. The same address can therefore take different probe orders under different base/offset splits.
- R3: A request is accepted on a clock edge where `req_valid` is high and both `busy` and `fill_valid` are low. If the steered way holds a valid matching tag, the response appears in the next cycle with `resp_valid` and `resp_hit` high, `resp_second` low and `resp_victim` 0.
- R4: If the steered way misses and the other way's rehash bit is set, `busy` is high for exactly one cycle after acceptance. The response then comes one cycle later with `resp_second` high, and it is a hit if the other way matches, otherwise a miss.
- R5: If the steered way misses and the other way's rehash bit is clear, the miss response comes in the cycle after acceptance with `resp_second` low and `busy` staying low.
- R6: A miss reports `resp_victim` as the opposite of the set's MRU bit. Every hit sets the MRU bit to the way that hit. Every refill sets it to the way filled. Steering bits never affect the victim.
- R7: Every hit writes the way that hit into the steering bit at that request's prediction index. Every refill writes the filled way into the steering bit at the missed request's prediction index.
- R8: A `fill_valid` pulse while not busy installs the tag of the most recent miss into the victim way that miss reported. It also sets that way's rehash bit in the set. A request driven in the same cycle is dropped and produces no response.
- R9: A request presented while `busy` is high is ignored and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Effective address of the request |
| req_base | input | 32 | Base-register value used to form the address |
| req_offset | input | 32 | Offset used to form the address |
| fill_valid | input | 1 | Refill pulse for the most recent miss |
| busy | output | 1 | High during the second-probe cycle |
| resp_valid | output | 1 | Response strobe, one cycle |
| resp_hit | output | 1 | Response is a hit |
| resp_second | output | 1 | Response was produced by the second probe |
| resp_miss | output | 1 | Response is a miss |
| resp_victim | output | 1 | Way to refill on a miss, 0 on a hit |

## Verification
A corrupted steering bit changes nothing in hit or miss outcomes. It shows only as a hit that arrives one cycle late with `resp_second` set, and it appears on the next access that uses the same prediction index. A wrong MRU bit shows on the next miss to that set as the wrong `resp_victim`. A wrong rehash bit shows as a missing or extra busy cycle, or as a line that can no longer be found. Mixing conflicting addresses in a few sets with random base/offset splits makes each of these faults appear within a few requests.

// File: rtl/psa_pkg.sv
package psa_pkg;
   typedef enum logic {
      ST_IDLE   = 1'b0,
      ST_PROBE2 = 1'b1
   } lk_state_t;
endpackage

// File: rtl/psa_bit_table.sv
module psa_bit_table #(
   parameter int DEPTH = 128,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_bit,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_bit
);
   generate
      if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
         $error("psa_bit_table: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [DEPTH-1:0] bits_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     bits_q <= '0;
      else if (wr_en) bits_q[wr_idx] <= wr_bit;
   end

   assign rd_bit = bits_q[rd_idx];

   assert_table_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> bits_q[$past(wr_idx)] == $past(wr_bit));
endmodule

// File: rtl/psa_tag_way.sv
module psa_tag_way #(
   parameter int SETS  = 128,
   parameter int TAG_W = 20,
   localparam int SET_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] rd_set,
   output logic [TAG_W-1:0] rd_tag,
   output logic             rd_valid,
   input  logic             wr_en,
   input  logic [SET_W-1:0] wr_set,
   input  logic [TAG_W-1:0] wr_tag
);
   generate
      if (TAG_W < 1) begin : g_bad_tag
         $error("psa_tag_way: TAG_W must be positive");
      end
   endgenerate

   logic [TAG_W-1:0] tags_q [SETS];
   logic [SETS-1:0]  valid_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     valid_q <= '0;
      else if (wr_en) valid_q[wr_set] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en) tags_q[wr_set] <= wr_tag;
   end

   assign rd_tag   = tags_q[rd_set];
   assign rd_valid = valid_q[rd_set];

   assert_fill_sticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> valid_q[$past(wr_set)] && tags_q[$past(wr_set)] == $past(wr_tag));
endmodule

// File: rtl/psa_pred_index.sv
module psa_pred_index #(
   parameter int ADDR_W = 32,
   parameter int LOFF_W = 5,
   parameter int PIDX_W = 8,
   parameter bit USE_XOR = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] offset,
   output logic [PIDX_W-1:0] pidx
);
   generate
      if (LOFF_W + PIDX_W > ADDR_W) begin : g_bad_width
         $error("psa_pred_index: index field exceeds address width");
      end
      if (USE_XOR) begin : g_xor_src
         logic [ADDR_W-1:0] folded;
         assign folded = base ^ offset;
         assign pidx   = folded[LOFF_W +: PIDX_W];
      end else begin : g_ea_src
         assign pidx = addr[LOFF_W +: PIDX_W];
      end
   endgenerate
endmodule

// File: rtl/psa_lookup_ctrl.sv
module psa_lookup_ctrl
   import psa_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 32,
   parameter int SETS       = 128,
   parameter int SBT_DEPTH  = 256,
   parameter bit USE_XOR    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [ADDR_W-1:0] req_base,
   input  logic [ADDR_W-1:0] req_offset,
   input  logic              fill_valid,
   output logic              busy,
   output logic              resp_valid,
   output logic              resp_hit,
   output logic              resp_second,
   output logic              resp_miss,
   output logic              resp_victim
);
   localparam int LOFF_W = $clog2(LINE_BYTES);
   localparam int SET_W  = $clog2(SETS);
   localparam int PIDX_W = $clog2(SBT_DEPTH);
   localparam int TAG_W  = ADDR_W - SET_W - LOFF_W;

   generate
      if (SBT_DEPTH < SETS) begin : g_bad_sbt
         $error("psa_lookup_ctrl: steering table must not be smaller than the set count");
      end
      if (TAG_W < 1) begin : g_bad_geom
         $error("psa_lookup_ctrl: no tag bits left");
      end
   endgenerate

   lk_state_t         st_q;
   logic [SET_W-1:0]  q_set, m_set, set_in, lk_set;
   logic [TAG_W-1:0]  q_tag, m_tag, tag_in, lk_tag;
   logic [PIDX_W-1:0] q_pidx, m_pidx, pidx_in, cur_pidx;
   logic              q_way, m_victim;

   assign set_in = req_addr[LOFF_W +: SET_W];
   assign tag_in = req_addr[ADDR_W-1 -: TAG_W];
   assign busy   = (st_q == ST_PROBE2);

   logic accept, fill_go;
   assign fill_go = fill_valid && !busy;
   assign accept  = req_valid && !fill_valid && !busy;

   assign lk_set   = busy ? q_set  : set_in;
   assign lk_tag   = busy ? q_tag  : tag_in;

   psa_pred_index #(.ADDR_W(ADDR_W), .LOFF_W(LOFF_W), .PIDX_W(PIDX_W), .USE_XOR(USE_XOR)) u_pidx (
      .addr(req_addr), .base(req_base), .offset(req_offset), .pidx(pidx_in));

   assign cur_pidx = busy ? q_pidx : pidx_in;

   logic [TAG_W-1:0] way_tag [2];
   logic [1:0]       way_valid, way_hit, rh_bit;

   for (genvar w = 0; w < 2; w++) begin : g_way
      logic fill_here;
      assign fill_here = fill_go && (m_victim == w[0]);

      psa_tag_way #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
         .clk(clk), .rst_n(rst_n), .rd_set(lk_set), .rd_tag(way_tag[w]), .rd_valid(way_valid[w]),
         .wr_en(fill_here), .wr_set(m_set), .wr_tag(m_tag));

      psa_bit_table #(.DEPTH(SETS)) u_rehash (
         .clk(clk), .rst_n(rst_n), .rd_idx(lk_set), .rd_bit(rh_bit[w]),
         .wr_en(fill_here), .wr_idx(m_set), .wr_bit(1'b1));

      assign way_hit[w] = way_valid[w] && (way_tag[w] == lk_tag);
   end

   logic steer_bit, mru_bit;
   logic probe_way, cur_hit, hit_upd, go_second, miss_now;
   logic tbl_we, tbl_wbit;

   assign probe_way = busy ? q_way : steer_bit;
   assign cur_hit   = way_hit[probe_way];
   assign hit_upd   = (accept || busy) && cur_hit;
   assign go_second = accept && !cur_hit && rh_bit[~steer_bit];
   assign miss_now  = (accept && !cur_hit && !rh_bit[~steer_bit]) || (busy && !cur_hit);
   assign tbl_we    = hit_upd || fill_go;
   assign tbl_wbit  = fill_go ? m_victim : probe_way;

   psa_bit_table #(.DEPTH(SBT_DEPTH)) u_steer (
      .clk(clk), .rst_n(rst_n), .rd_idx(pidx_in), .rd_bit(steer_bit),
      .wr_en(tbl_we), .wr_idx(fill_go ? m_pidx : cur_pidx), .wr_bit(tbl_wbit));

   psa_bit_table #(.DEPTH(SETS)) u_mru (
      .clk(clk), .rst_n(rst_n), .rd_idx(lk_set), .rd_bit(mru_bit),
      .wr_en(tbl_we), .wr_idx(fill_go ? m_set : lk_set), .wr_bit(tbl_wbit));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         resp_valid  <= 1'b0;
         resp_hit    <= 1'b0;
         resp_second <= 1'b0;
         resp_miss   <= 1'b0;
         resp_victim <= 1'b0;
         q_set <= '0; q_tag <= '0; q_pidx <= '0; q_way <= 1'b0;
         m_set <= '0; m_tag <= '0; m_pidx <= '0; m_victim <= 1'b0;
      end else begin
         st_q        <= go_second ? ST_PROBE2 : ST_IDLE;
         resp_valid  <= hit_upd || miss_now;
         resp_hit    <= hit_upd;
         resp_miss   <= miss_now;
         resp_second <= busy;
         resp_victim <= miss_now ? ~mru_bit : 1'b0;
         if (go_second) begin
            q_set  <= set_in;
            q_tag  <= tag_in;
            q_pidx <= pidx_in;
            q_way  <= ~steer_bit;
         end
         if (miss_now) begin
            m_set    <= lk_set;
            m_tag    <= lk_tag;
            m_pidx   <= cur_pidx;
            m_victim <= ~mru_bit;
         end
      end
   end

   assert_one_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> (resp_hit != resp_miss));
   assert_first_resp_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && !resp_second) |-> $past(req_valid && !fill_valid && !busy));
   assert_busy_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy);
   assert_second_after_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_second) |-> $past(busy));
   assert_busy_has_answer_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (resp_valid && resp_second));
   assert_fill_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && !busy) |=> (!resp_valid && !busy));
   assert_hit_no_victim_R6: assert property (@(posedge clk) disable iff (!rst_n)
      resp_hit |-> !resp_victim);
endmodule

// File: tb/sim_psa_lookup_ctrl.sv
module sim_psa_lookup_ctrl;
   timeunit 1ns;
   timeprecision 1ps;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0, req_base = '0, req_offset = '0;
   logic        fill_valid = 1'b0;
   logic        busy, resp_valid, resp_hit, resp_second, resp_miss, resp_victim;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   psa_lookup_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_base(req_base), .req_offset(req_offset), .fill_valid(fill_valid),
      .busy(busy), .resp_valid(resp_valid), .resp_hit(resp_hit),
      .resp_second(resp_second), .resp_miss(resp_miss), .resp_victim(resp_victim));

   // behavioural model of the requirements
   logic [19:0] md_tag [2][128];
   bit          md_val [2][128];
   bit          md_rh  [2][128];
   bit          md_mru [128];
   bit          md_sbt [256];
   int          pm_set = 0, pm_pidx = 0;
   logic [19:0] pm_tag = '0;
   bit          pm_vic = 1'b0;

   task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", rq, act, exp);
      end
   endtask

   function automatic logic [7:0] outs();
      return {3'b0, busy, resp_valid, resp_hit, resp_second, resp_miss} << 1 | {7'b0, resp_victim};
   endfunction

   function automatic logic [7:0] mk(bit b, bit v, bit h, bit s, bit m, bit vic);
      return {2'b0, b, v, h, s, m, vic};
   endfunction

   task automatic do_req(input logic [31:0] base, input logic [31:0] off, input bit hold, input string tag_rq);
      logic [31:0] a;
      int s, p;
      logic [19:0] t;
      bit sw, two, ehit, way, evic;
      string rq;
      a = base + off;
      s = int'(a[11:5]);
      t = a[31:12];
      p = int'(((base ^ off) >> 5) & 32'hFF);
      sw = md_sbt[p];
      two = 1'b0; ehit = 1'b0; way = 1'b0; evic = 1'b0;
      if (md_val[sw][s] && md_tag[sw][s] == t) begin
         ehit = 1'b1; way = sw;
      end else if (md_rh[!sw][s]) begin
         two = 1'b1;
         if (md_val[!sw][s] && md_tag[!sw][s] == t) begin ehit = 1'b1; way = !sw; end
         else evic = !md_mru[s];
      end else begin
         evic = !md_mru[s];
      end
      if (ehit) begin
         md_mru[s] = way; md_sbt[p] = way;
      end else begin
         pm_set = s; pm_tag = t; pm_pidx = p; pm_vic = evic;
      end
      rq = two ? {tag_rq, " R4"} : (ehit ? {tag_rq, " R3 R7"} : {tag_rq, " R5 R6"});
      @(negedge clk);
      req_valid = 1'b1; req_base = base; req_offset = off; req_addr = a;
      @(negedge clk);
      if (two) begin
         chk({rq, " busy"}, {6'b0, busy, resp_valid}, 8'b10);
         if (hold) begin
            req_addr = a ^ 32'h0005_3000; req_base = base ^ 32'h60; // R9 request while busy
         end else req_valid = 1'b0;
         @(negedge clk);
      end
      req_valid = 1'b0;
      chk(rq, {2'b0, busy, resp_valid, resp_hit, resp_second, resp_miss, resp_victim},
          mk(1'b0, 1'b1, ehit, two, !ehit, ehit ? 1'b0 : evic));
      if (hold && two) begin
         @(negedge clk);
         chk("R9 ignored while busy", {6'b0, busy, resp_valid}, 8'b0);
      end
   endtask

   task automatic do_fill(input bit with_req);
      md_tag[pm_vic][pm_set] = pm_tag;
      md_val[pm_vic][pm_set] = 1'b1;
      md_rh[pm_vic][pm_set]  = 1'b1;
      md_mru[pm_set]         = pm_vic;
      md_sbt[pm_pidx]        = pm_vic;
      @(negedge clk);
      fill_valid = 1'b1;
      if (with_req) begin
         req_valid = 1'b1; req_base = 32'h0009_9060; req_offset = '0; req_addr = 32'h0009_9060;
      end
      @(negedge clk);
      fill_valid = 1'b0; req_valid = 1'b0;
      chk("R8 fill quiet", {6'b0, busy, resp_valid}, 8'b0);
      if (with_req) begin
         @(negedge clk);
         chk("R8 same-cycle request dropped", {6'b0, busy, resp_valid}, 8'b0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 128; i++) begin
         md_val[0][i] = 0; md_val[1][i] = 0; md_rh[0][i] = 0; md_rh[1][i] = 0;
         md_mru[i] = 0; md_tag[0][i] = '0; md_tag[1][i] = '0;
      end
      for (int i = 0; i < 256; i++) md_sbt[i] = 0;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset outputs", {2'b0, busy, resp_valid, resp_hit, resp_second, resp_miss, resp_victim}, 8'b0);

      // R1: cold miss, one probe, victim way 1
      do_req(32'h0001_2060, 32'h0, 1'b0, "R1");
      chk("R1 cold victim", {7'b0, resp_victim}, 8'd1);
      do_fill(1'b0);
      do_req(32'h0001_2060, 32'h0, 1'b0, "R7 steered hit");
      chk("R3 first-probe hit", {5'b0, resp_hit, resp_second, resp_miss}, 8'b100);
      // conflicting line in set 3 with a different prediction index
      do_req(32'h0003_4030, 32'h30, 1'b0, "R6 conflict");
      chk("R6 victim opposite MRU", {7'b0, resp_victim}, 8'd0);
      do_fill(1'b1);
      // R2: same address, carry-producing split gives another steering index
      do_req(32'h0001_2030, 32'h30, 1'b0, "R2 split");
      chk("R2 second-probe hit", {5'b0, resp_hit, resp_second, resp_miss}, 8'b110);
      do_req(32'h0001_2030, 32'h30, 1'b0, "R7 retrained");
      chk("R7 now first probe", {5'b0, resp_hit, resp_second, resp_miss}, 8'b100);
      // R9: new tag in full set, second probe with a request held during busy
      do_req(32'h0007_7060, 32'h0, 1'b1, "R9");
      do_fill(1'b0);
      // R5: other way empty in a fresh set
      do_req(32'h0000_50A0, 32'h0, 1'b0, "R5");
      do_fill(1'b0);
      do_req(32'h0000_5080, 32'h20, 1'b0, "R5 empty partner");

      for (int k = 0; k < 1500; k++) begin
         logic [31:0] addr, base;
         int sel;
         sel = int'($urandom_range(0, 2));
         addr = {12'h0, $urandom_range(1, 4) * 8'h1, (sel == 0) ? 12'h060 : (sel == 1) ? 12'h9A0 : 12'hFE0};
         addr[31:12] = 20'($urandom_range(1, 4));
         base = $urandom;
         do_req(base, addr - base, ($urandom_range(0, 7) == 0), "rand");
         if (resp_miss && $urandom_range(0, 9) < 8) do_fill($urandom_range(0, 5) == 0);
         if ($urandom_range(0, 3) == 0) @(negedge clk);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule